// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns the addressing byte of an instruction into a memory location. From the 2-bit mode field and the 3-bit r/m field it picks a mix of base register, index register and displacement, and adds them into a 16-bit offset. It then selects a segment register and forms a 20-bit physical address. It also reports whether the operand is a register rather than memory, and whether a word access must be split into two bus cycles.

The default segment is the stack segment when BP takes part in the address, and the data segment in every other case. A segment-override input can replace that choice with any of the four segment registers. Each accepted request produces one registered result. The result is held at the output until the consumer takes it.

Top module: `eag_top`

## Requirements
- R1: With mode 00 and an r/m code other than 110, the offset is BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, (110 excepted) or BX for r/m codes 000 through 111, with no displacement added.
- R2: With mode 01, the offset is the r/m base/index sum of R1 (110 giving BP) plus disp_lo sign-extended from bit 7 to 16 bits.
- R3: With mode 10, the offset is the r/m base/index sum plus the 16-bit displacement {disp_hi, disp_lo}.
- R4: Mode 00 with r/m 110 gives a direct offset equal to {disp_hi, disp_lo}, with no register added.
- R5: With no override, the segment code is SS (2) when BP is in the sum (r/m 010, 011, or 110 outside mode 00) and DS (3) otherwise. The segment codes are ES=0, CS=1, SS=2, DS=3.
- R6: When ovr_en is 1, the segment code is ovr_sel, and that segment register's value is used for the physical address.
- R7: The offset wraps modulo 2^16. out_phys equals (segment value shifted left 4) plus the offset, wrapped modulo 2^20.
- R8: Mode 11 raises out_is_reg and drives out_offset, out_phys and out_split to 0.
- R9: out_split is 1 exactly when word_acc is 1, the operand is in memory and out_phys is odd.
- R10: out_valid rises in the clock after a request is accepted (in_valid and in_ready both 1). While out_ready is 0, out_valid and all result outputs hold, and in_ready is 0. in_ready equals !out_valid || out_ready.
- R11: After a synchronous active-low reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| mode | input | 2 | Addressing mode field |
| rm | input | 3 | r/m field |
| disp_lo | input | 8 | Displacement low byte |
| disp_hi | input | 8 | Displacement high byte |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_es | input | 16 | Extra segment value |
| seg_cs | input | 16 | Code segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ds | input | 16 | Data segment value |
| ovr_en | input | 1 | Segment override active |
| ovr_sel | input | 2 | Override segment code |
| word_acc | input | 1 | 1 for word access, 0 for byte access |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_offset | output | 16 | Effective offset |
| out_seg_id | output | 2 | Selected segment code |
| out_phys | output | 20 | Physical address |
| out_is_reg | output | 1 | Operand is a register |
| out_split | output | 1 | Word access needs two bus cycles |

## Verification
Each fault in the datapath shows up in the result of the very request that exercises it, one clock after acceptance:
- A wrong base/index choice or a wrong displacement form appears as a bad out_offset.
- A mistaken default segment or override appears in out_seg_id, and in out_phys through a distinct segment value.
- A lost carry or a missing wrap shows only with operands placed near 2^16 and 2^20.

A faulty output register is seen at the ports as a result that changes, or a valid that drops, while out_ready is held low.

// File: rtl/eag_pkg.sv
// Shared types for the effective address generator.
// Assumes the segment code order ES, CS, SS, DS used at the top ports.
package eag_pkg;
    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_id_e;

    localparam logic [1:0] MODE_NODISP = 2'b00;
    localparam logic [1:0] MODE_DISP8  = 2'b01;
    localparam logic [1:0] MODE_DISP16 = 2'b10;
    localparam logic [1:0] MODE_REG    = 2'b11;
    localparam logic [2:0] RM_DIRECT  = 3'b110;
endpackage

// File: rtl/eag_offset_calc.sv
// Offset calculator: forms the 16-bit effective offset from mode, r/m,
// the displacement bytes and the base/index registers.
// It also reports whether BP is in the sum and whether the operand is a register.
// Assumes the offset is exactly two displacement bytes wide.
module eag_offset_calc
    import eag_pkg::*;
#(
    parameter int DISP_W = 8,
    localparam int OFS_W = 2 * DISP_W
) (
    input  logic [1:0]        mode,
    input  logic [2:0]        rm,
    input  logic [DISP_W-1:0] disp_lo,
    input  logic [DISP_W-1:0] disp_hi,
    input  logic [OFS_W-1:0]  reg_bx,
    input  logic [OFS_W-1:0]  reg_bp,
    input  logic [OFS_W-1:0]  reg_si,
    input  logic [OFS_W-1:0]  reg_di,
    output logic [OFS_W-1:0]  offset,
    output logic              uses_bp,
    output logic              is_reg
);
    logic [OFS_W-1:0] disp_ext;
    logic [OFS_W-1:0] base_sum;
    logic             direct;

    // Pick the displacement form selected by the mode field.
    always_comb begin
        case (mode)
            MODE_DISP8:  disp_ext = {{DISP_W{disp_lo[DISP_W-1]}}, disp_lo};
            MODE_DISP16: disp_ext = {disp_hi, disp_lo};
            default:     disp_ext = '0;
        endcase
    end

    // Pick the base/index sum selected by r/m.
    always_comb begin
        case (rm)
            3'b000:  base_sum = reg_bx + reg_si;
            3'b001:  base_sum = reg_bx + reg_di;
            3'b010:  base_sum = reg_bp + reg_si;
            3'b011:  base_sum = reg_bp + reg_di;
            3'b100:  base_sum = reg_si;
            3'b101:  base_sum = reg_di;
            3'b110:  base_sum = reg_bp;
            default: base_sum = reg_bx;
        endcase
    end

    // Resolve the special direct form, the register form and the BP flag.
    always_comb begin
        direct  = (mode == MODE_NODISP) && (rm == RM_DIRECT);
        is_reg  = (mode == MODE_REG);
        uses_bp = !is_reg && !direct &&
                  ((rm == 3'b010) || (rm == 3'b011) || (rm == 3'b110));
        if (is_reg)
            offset = '0;
        else if (direct)
            offset = {disp_hi, disp_lo};
        else
            offset = base_sum + disp_ext;
    end
endmodule

// File: rtl/eag_seg_select.sv
// Segment selector: chooses the default segment (stack segment when BP is used,
// data segment otherwise), or the override, and returns its code and value.
// Assumes the four segment values arrive in code order ES, CS, SS, DS.
module eag_seg_select
    import eag_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int N_SEG = 4,
    localparam int SID_W = $clog2(N_SEG)
) (
    input  logic [N_SEG-1:0][SEG_W-1:0] seg_vals,
    input  logic                        uses_bp,
    input  logic                        ovr_en,
    input  logic [SID_W-1:0]            ovr_sel,
    output logic [SID_W-1:0]            seg_id,
    output logic [SEG_W-1:0]            seg_val
);
    // Choose the segment code, then index the segment value by that code.
    always_comb begin
        if (ovr_en)
            seg_id = ovr_sel;
        else if (uses_bp)
            seg_id = SID_W'(SEG_SS);
        else
            seg_id = SID_W'(SEG_DS);
        seg_val = seg_vals[seg_id];
    end
endmodule

// File: rtl/eag_phys_add.sv
// Physical address adder: shifts the segment value left, adds the offset
// (wrapping at the address width), and flags odd word accesses.
// Assumes the offset and segment widths are equal.
module eag_phys_add #(
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int PA_W     = OFS_W + SEG_SHIFT
) (
    input  logic [OFS_W-1:0] seg_val,
    input  logic [OFS_W-1:0] offset,
    input  logic             word_acc,
    input  logic             is_reg,
    output logic [PA_W-1:0]  phys,
    output logic             split
);
    // Form the wrapped physical address and the two-cycle indication.
    always_comb begin
        if (is_reg)
            phys = '0;
        else
            phys = {seg_val, {SEG_SHIFT{1'b0}}} + PA_W'(offset);
        split = word_acc && !is_reg && phys[0];
    end
endmodule

// File: rtl/eag_top.sv
// Effective address generator top: the combinational address path with one
// output register and a valid/ready handshake.
// Assumes the consumer holds out_ready stable except at clock edges.
module eag_top
    import eag_pkg::*;
#(
    parameter int DISP_W    = 8,
    parameter int SEG_SHIFT = 4,
    localparam int OFS_W    = 2 * DISP_W,
    localparam int PA_W     = OFS_W + SEG_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        mode,
    input  logic [2:0]        rm,
    input  logic [DISP_W-1:0] disp_lo,
    input  logic [DISP_W-1:0] disp_hi,
    input  logic [OFS_W-1:0]  reg_bx,
    input  logic [OFS_W-1:0]  reg_bp,
    input  logic [OFS_W-1:0]  reg_si,
    input  logic [OFS_W-1:0]  reg_di,
    input  logic [OFS_W-1:0]  seg_es,
    input  logic [OFS_W-1:0]  seg_cs,
    input  logic [OFS_W-1:0]  seg_ss,
    input  logic [OFS_W-1:0]  seg_ds,
    input  logic              ovr_en,
    input  logic [1:0]        ovr_sel,
    input  logic              word_acc,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OFS_W-1:0]  out_offset,
    output logic [1:0]        out_seg_id,
    output logic [PA_W-1:0]   out_phys,
    output logic              out_is_reg,
    output logic              out_split
);
    logic [OFS_W-1:0]         c_offset;
    logic                     c_uses_bp;
    logic                     c_is_reg;
    logic [1:0]               c_seg_id;
    logic [OFS_W-1:0]         c_seg_val;
    logic [PA_W-1:0]          c_phys;
    logic                     c_split;
    logic [3:0][OFS_W-1:0]    seg_vals;
    logic                     accept;

    assign seg_vals = {seg_ds, seg_ss, seg_cs, seg_es};
    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;

    eag_offset_calc #(.DISP_W(DISP_W)) u_ofs (
        .mode(mode), .rm(rm), .disp_lo(disp_lo), .disp_hi(disp_hi),
        .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
        .offset(c_offset), .uses_bp(c_uses_bp), .is_reg(c_is_reg)
    );

    eag_seg_select #(.SEG_W(OFS_W), .N_SEG(4)) u_seg (
        .seg_vals(seg_vals), .uses_bp(c_uses_bp), .ovr_en(ovr_en),
        .ovr_sel(ovr_sel), .seg_id(c_seg_id), .seg_val(c_seg_val)
    );

    eag_phys_add #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_add (
        .seg_val(c_seg_val), .offset(c_offset), .word_acc(word_acc),
        .is_reg(c_is_reg), .phys(c_phys), .split(c_split)
    );

    // Output valid flag: set on accept, cleared when the result is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else if (accept)
            out_valid <= 1'b1;
        else if (out_ready)
            out_valid <= 1'b0;
    end

    // Result register: loads only on accept, so it holds under backpressure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_offset <= '0;
            out_seg_id <= '0;
            out_phys   <= '0;
            out_is_reg <= 1'b0;
            out_split  <= 1'b0;
        end else if (accept) begin
            out_offset <= c_offset;
            out_seg_id <= c_seg_id;
            out_phys   <= c_phys;
            out_is_reg <= c_is_reg;
            out_split  <= c_split;
        end
    end

    AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R10
    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_phys) && $stable(out_offset))); // R10
    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R10
    AST_REG_NO_ADDRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_reg) |-> (out_phys == '0 && out_offset == '0 && !out_split)); // R8
    AST_SPLIT_ONLY_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_split) |-> (out_phys[0] && !out_is_reg)); // R9
    AST_LOW_NIBBLE_FROM_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_reg) |-> (out_phys[SEG_SHIFT-1:0] == out_offset[SEG_SHIFT-1:0])); // R7
endmodule

// File: tb/eag_top_bench.sv
module eag_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_ready;
    logic [1:0]  mode;
    logic [2:0]  rm;
    logic [7:0]  disp_lo, disp_hi;
    logic [15:0] reg_bx, reg_bp, reg_si, reg_di;
    logic [15:0] seg_es, seg_cs, seg_ss, seg_ds;
    logic        ovr_en;
    logic [1:0]  ovr_sel;
    logic        word_acc;
    logic        out_valid, out_ready;
    logic [15:0] out_offset;
    logic [1:0]  out_seg_id;
    logic [19:0] out_phys;
    logic        out_is_reg, out_split;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eag_top u_eag_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .mode(mode), .rm(rm), .disp_lo(disp_lo), .disp_hi(disp_hi),
        .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
        .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .ovr_en(ovr_en), .ovr_sel(ovr_sel), .word_acc(word_acc),
        .out_valid(out_valid), .out_ready(out_ready), .out_offset(out_offset),
        .out_seg_id(out_seg_id), .out_phys(out_phys), .out_is_reg(out_is_reg),
        .out_split(out_split)
    );

    task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] seg_of(input logic [1:0] id);
        case (id)
            2'd0:    return seg_es;
            2'd1:    return seg_cs;
            2'd2:    return seg_ss;
            default: return seg_ds;
        endcase
    endfunction

    // Request a translation, then compare every result field with values
    // worked out from the requirements.
    task automatic run(input string tag, input logic [1:0] m, input logic [2:0] r,
                       input logic [7:0] dl, input logic [7:0] dh,
                       input logic oe, input logic [1:0] os, input logic wa);
        logic [15:0] base, disp, off;
        logic [1:0]  sid;
        logic [19:0] pa;
        logic        bp_used, spl;
        case (r)
            3'd0: base = reg_bx + reg_si;
            3'd1: base = reg_bx + reg_di;
            3'd2: base = reg_bp + reg_si;
            3'd3: base = reg_bp + reg_di;
            3'd4: base = reg_si;
            3'd5: base = reg_di;
            3'd6: base = reg_bp;
            default: base = reg_bx;
        endcase
        disp = (m == 2'b01) ? {{8{dl[7]}}, dl} : (m == 2'b10) ? {dh, dl} : 16'h0;
        bp_used = (r == 3'd2) || (r == 3'd3) || (r == 3'd6 && m != 2'b00);
        off = (m == 2'b00 && r == 3'd6) ? {dh, dl} : base + disp;
        sid = oe ? os : (bp_used ? 2'd2 : 2'd3);
        pa  = {seg_of(sid), 4'h0} + {4'h0, off};
        spl = wa & pa[0];
        if (m == 2'b11) begin off = 0; pa = 0; spl = 0; end
        @(negedge clk);
        mode = m; rm = r; disp_lo = dl; disp_hi = dh;
        ovr_en = oe; ovr_sel = os; word_acc = wa; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"},  {19'h0, out_valid}, 20'h1);
        check({tag, " offset"}, {4'h0, out_offset}, {4'h0, off});
        check({tag, " phys"},   out_phys, pa);
        check({tag, " split"},  {19'h0, out_split}, {19'h0, spl});
        check({tag, " isreg"},  {19'h0, out_is_reg}, {19'h0, (m == 2'b11)});
        if (m != 2'b11)
            check({tag, " seg"}, {18'h0, out_seg_id}, {18'h0, sid});
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R11 reset valid", {19'h0, out_valid}, 20'h0);
        check("R11 reset ready", {19'h0, in_ready}, 20'h1);
    endtask

    task automatic t_nodisp();
        for (int i = 0; i < 8; i++)
            if (i != 6) run("R1 R5 mode00", 2'b00, 3'(i), 8'hAA, 8'h55, 1'b0, 2'd0, 1'b0);
    endtask

    task automatic t_disp8();
        for (int i = 0; i < 8; i++) begin
            run("R2 R5 disp8 neg", 2'b01, 3'(i), 8'h80, 8'h77, 1'b0, 2'd0, 1'b0);
            run("R2 disp8 pos", 2'b01, 3'(i), 8'h7F, 8'h77, 1'b0, 2'd0, 1'b0);
        end
    endtask

    task automatic t_disp16();
        for (int i = 0; i < 8; i++)
            run("R3 R5 disp16", 2'b10, 3'(i), 8'h34, 8'h92, 1'b0, 2'd0, 1'b0);
    endtask

    task automatic t_direct();
        run("R4 direct", 2'b00, 3'd6, 8'hCD, 8'hAB, 1'b0, 2'd0, 1'b0);
        check("R4 R5 direct seg is DS", {18'h0, out_seg_id}, 20'h3);
        check("R4 direct offset", {4'h0, out_offset}, 20'h0ABCD);
    endtask

    task automatic t_override();
        for (int s = 0; s < 4; s++) begin
            run("R6 ovr bp", 2'b01, 3'd6, 8'h02, 8'h00, 1'b1, 2'(s), 1'b0);
            run("R6 ovr bx", 2'b00, 3'd7, 8'h00, 8'h00, 1'b1, 2'(s), 1'b0);
        end
    endtask

    task automatic t_wrap();
        // DI=FFF1 + disp 0020 wraps to 0011 inside 16 bits.
        run("R7 ofs wrap", 2'b10, 3'd5, 8'h20, 8'h00, 1'b0, 2'd0, 1'b0);
        check("R7 ofs wrap value", {4'h0, out_offset}, 20'h00011);
        // ES=FFFF: FFFF0 + 0020 wraps to 00010 inside 20 bits.
        run("R7 pa wrap", 2'b00, 3'd6, 8'h20, 8'h00, 1'b1, 2'd0, 1'b0);
        check("R7 pa wrap value", out_phys, 20'h00010);
    endtask

    task automatic t_register();
        run("R8 reg", 2'b11, 3'd3, 8'h11, 8'h22, 1'b0, 2'd0, 1'b1);
        run("R8 reg ovr", 2'b11, 3'd7, 8'h01, 8'h00, 1'b1, 2'd1, 1'b1);
    endtask

    task automatic t_split();
        run("R9 word odd", 2'b00, 3'd6, 8'h01, 8'h10, 1'b0, 2'd0, 1'b1);
        check("R9 odd split", {19'h0, out_split}, 20'h1);
        run("R9 word even", 2'b00, 3'd6, 8'h02, 8'h10, 1'b0, 2'd0, 1'b1);
        check("R9 even no split", {19'h0, out_split}, 20'h0);
        run("R9 byte odd", 2'b00, 3'd6, 8'h01, 8'h10, 1'b0, 2'd0, 1'b0);
        check("R9 byte no split", {19'h0, out_split}, 20'h0);
    endtask

    task automatic t_backpressure();
        logic [19:0] held;
        @(negedge clk);
        out_ready = 1'b0;
        run("R10 stall first", 2'b00, 3'd6, 8'h44, 8'h33, 1'b0, 2'd0, 1'b0);
        held = out_phys;
        check("R10 stall ready low", {19'h0, in_ready}, 20'h0);
        mode = 2'b00; rm = 3'd6; disp_lo = 8'h99; disp_hi = 8'h88; in_valid = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 held valid", {19'h0, out_valid}, 20'h1);
        check("R10 held phys", out_phys, held);
        check("R10 held offset", {4'h0, out_offset}, 20'h03344);
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        check("R10 drained", {19'h0, out_valid}, 20'h0);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        mode = 0; rm = 0; disp_lo = 0; disp_hi = 0;
        ovr_en = 0; ovr_sel = 0; word_acc = 0;
        reg_bx = 16'h1234; reg_bp = 16'h8000; reg_si = 16'h0010; reg_di = 16'hFFF1;
        seg_es = 16'hF000; seg_cs = 16'h1000; seg_ss = 16'h3000; seg_ds = 16'h2000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_nodisp();
        t_disp8();
        t_disp16();
        t_direct();
        t_override();
        seg_es = 16'hFFFF;
        t_wrap();
        seg_es = 16'hF000;
        t_register();
        t_split();
        t_backpressure();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule